// File: doc/BRIEF.md
# Interrupt Delivery Engine

This block turns per-pin interrupt inputs into interrupt message writes. Each pin has a 64-bit redirection entry. The entry picks edge or level behaviour, a mask, a vector, a delivery mode, a destination-mode bit and a 16-bit destination field. The block keeps one pending bit per pin. Pins that are pending, unmasked and free to deliver are served lowest index first. Each served pin produces one 32-bit address / 32-bit data message, presented on a valid/ready output.

A level-mode pin sets a remote-pending flag in its entry when it is delivered. It cannot deliver again until an end-of-interrupt carrying a matching vector clears that flag. If the pin is still asserted at that point, it is delivered again. Edge-mode pins clear their pending bit when delivered. A rising edge that arrives while the pin is masked is discarded. Physical input 0 is steered onto entry 2.

Register decode sits outside this block. It writes whole entries through a write port and reads them back through a read port. An external-vector input supplies the vector for entries whose delivery mode asks for it.

Top module: `irq_route_engine`

## Requirements
- R1: After reset, msgValid is low and every entry reads 64'h0000_0000_0001_0000 (masked, all other fields zero, remote-pending clear).
- R2: Physical input 0 acts on entry 2 (ORed with input 2). Entry 0 never receives a request.
- R3: A rising input on an unmasked edge-mode entry (entry bit 15 = 0, bit 16 = 0) produces exactly one message, even while the input stays high.
- R4: A rising input on a masked edge-mode entry (bit 16 = 1) is discarded. Clearing the mask afterwards emits nothing.
- R5: A high input on an unmasked level-mode entry (bit 15 = 1) produces one message and sets remote-pending (entry bit 14). No further message follows while bit 14 stays set.
- R6: An end-of-interrupt whose vector equals bits 7:0 of an entry with bit 14 set clears bit 14. If the input is still high, the pin is delivered again. A non-matching vector changes nothing.
- R7: A masked level-mode entry with a high input emits nothing but stays pending. Clearing the mask with an entry write delivers it.
- R8: When several entries are ready together, messages leave in ascending entry index.
- R9: The message address is 32'hFEE00000 | (entry[63:48] << 4) | (entry[11] << 2). The message data is vector | (entry[10:8] << 8) | (entry[15] << 15).
- R10: When the delivery mode entry[10:8] is 3'b111, the message vector is taken from extVector instead of entry[7:0].
- R11: While msgValid is high and msgReady is low, msgValid, msgAddr and msgData hold. Only one message is outstanding at a time.
- R12: Entry bit 14 cannot be written. An entry write that selects edge mode clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | NUM_PINS | Raw interrupt input levels |
| entryWrEn | input | 1 | Write strobe for one redirection entry |
| entryWrIdx | input | IDXW | Entry index to write |
| entryWrData | input | 64 | New entry value (bit 14 ignored) |
| entryRdIdx | input | IDXW | Entry index to read |
| entryRdData | output | 64 | Entry contents, including remote-pending at bit 14 |
| eoiValid | input | 1 | End-of-interrupt strobe |
| eoiVector | input | 8 | End-of-interrupt vector |
| extVector | input | 8 | Vector used by external-vector delivery mode |
| msgValid | output | 1 | Message available |
| msgReady | input | 1 | Message accepted when high with msgValid |
| msgAddr | output | 32 | Message address |
| msgData | output | 32 | Message data |

## Verification
Every input from 1 to 7 is driven in edge mode with a different destination, mode and vector. This checks that address and data are built per entry and that a held-high input gives a single message. Level inputs are held high across end-of-interrupts: a matching vector must cause re-delivery, a mismatching one must not, and one that arrives with the input low must not either. Together these separate the level path from the edge path. Three edge inputs are raised in the same cycle while ready is held low. This exposes both the priority order and whether the output holds under stall. Mask toggles separate an edge request that is discarded from a level request that is kept.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int IDX_STROBE_W = 8;

  localparam int VEC_LSB   = 0;
  localparam int DLV_LSB   = 8;
  localparam int DMODE_BIT = 11;
  localparam int RPEND_BIT = 14;
  localparam int TRIG_BIT  = 15;
  localparam int MASK_BIT  = 16;
  localparam int DEST_LSB  = 48;

  localparam logic [2:0]  DLV_EXTERNAL = 3'b111;
  localparam logic [31:0] MSG_BASE     = 32'hFEE0_0000;
  localparam logic [63:0] ENTRY_RESET  = 64'h0000_0000_0001_0000;

  typedef struct packed {
    logic                    fire;
    logic [IDX_STROBE_W-1:0] idx;
  } fire_strobe_t;

  function automatic logic [31:0] buildAddr(input logic [63:0] ent);
    logic [31:0] a;
    a = MSG_BASE;
    a[19:4] = ent[DEST_LSB +: 16];
    a[2]    = ent[DMODE_BIT];
    return a;
  endfunction

  function automatic logic [31:0] buildData(input logic [63:0] ent, input logic [7:0] ext);
    logic [31:0] d;
    logic [2:0]  dlv;
    dlv = ent[DLV_LSB +: 3];
    d = '0;
    d[7:0]  = (dlv == DLV_EXTERNAL) ? ext : ent[VEC_LSB +: 8];
    d[10:8] = dlv;
    d[15]   = ent[TRIG_BIT];
    return d;
  endfunction

endpackage

// File: rtl/irq_route_dp.sv
module irq_route_dp
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDXW     = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                wrEn,
  input  logic [IDXW-1:0]     wrIdx,
  input  logic [63:0]         wrData,
  input  logic [IDXW-1:0]     rdIdx,
  output logic [63:0]         rdData,
  input  logic                eoiValid,
  input  logic [7:0]          eoiVector,
  input  logic [7:0]          extVector,
  input  fire_strobe_t        strb,
  output logic [NUM_PINS-1:0] eligible,
  output logic [NUM_PINS-1:0] pendVec,
  output logic [NUM_PINS-1:0] remoteVec,
  output logic [NUM_PINS-1:0] maskVec,
  output logic [NUM_PINS-1:0] levelVec,
  output logic [31:0]         msgAddr,
  output logic [31:0]         msgData
);

  logic [63:0]         tableQ [NUM_PINS];
  logic [NUM_PINS-1:0] pendQ, remoteQ, prevQ;
  logic [NUM_PINS-1:0] pendNext, remoteNext;
  logic [NUM_PINS-1:0] mappedIn, riseVec, fireHit, wrHit;
  logic [63:0]         selEntry;
  logic [31:0]         addrQ, dataQ;

  // input steering: physical 0 lands on entry 2, entry 0 sees nothing
  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : gMap
      if (g == 0) begin : gZero
        assign mappedIn[g] = 1'b0;
      end else if (g == 2) begin : gTwo
        assign mappedIn[g] = pinIn[0] | pinIn[2];
      end else begin : gSame
        assign mappedIn[g] = pinIn[g];
      end
      assign riseVec[g]  = mappedIn[g] & ~prevQ[g];
      assign maskVec[g]  = tableQ[g][MASK_BIT];
      assign levelVec[g] = tableQ[g][TRIG_BIT];
      assign fireHit[g]  = strb.fire && (strb.idx == IDX_STROBE_W'(g));
      assign wrHit[g]    = wrEn && (wrIdx == IDXW'(g));
      assign eligible[g] = pendQ[g] & ~maskVec[g] & (~levelVec[g] | ~remoteQ[g]);
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      if (levelVec[i])                    pendNext[i] = mappedIn[i];
      else if (riseVec[i] && !maskVec[i]) pendNext[i] = 1'b1;
      else if (fireHit[i])                pendNext[i] = 1'b0;
      else                                pendNext[i] = pendQ[i];

      remoteNext[i] = remoteQ[i];
      if (eoiValid && remoteQ[i] && (tableQ[i][VEC_LSB +: 8] == eoiVector))
        remoteNext[i] = 1'b0;
      if (fireHit[i] && levelVec[i])
        remoteNext[i] = 1'b1;
      if (wrHit[i] && !wrData[TRIG_BIT])
        remoteNext[i] = 1'b0;
    end
  end

  always_comb begin
    selEntry = '0;
    rdData   = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (strb.idx == IDX_STROBE_W'(i)) selEntry = tableQ[i];
      if (rdIdx == IDXW'(i)) begin
        rdData = tableQ[i];
        rdData[RPEND_BIT] = remoteQ[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PINS; i++) tableQ[i] <= ENTRY_RESET;
      pendQ   <= '0;
      remoteQ <= '0;
      prevQ   <= '0;
      addrQ   <= '0;
      dataQ   <= '0;
    end else begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (wrHit[i]) tableQ[i] <= wrData & ~(64'd1 << RPEND_BIT);
      end
      pendQ   <= pendNext;
      remoteQ <= remoteNext;
      prevQ   <= mappedIn;
      if (strb.fire) begin
        addrQ <= buildAddr(selEntry);
        dataQ <= buildData(selEntry, extVector);
      end
    end
  end

  assign pendVec   = pendQ;
  assign remoteVec = remoteQ;
  assign msgAddr   = addrQ;
  assign msgData   = dataQ;

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] eligible,
  input  logic                msgReady,
  output fire_strobe_t        strb,
  output logic                msgValid
);

  logic                    validQ;
  logic [IDX_STROBE_W-1:0] pickIdx;
  logic                    canLoad;

  // lowest eligible index wins: scan downward so the last hit is the lowest
  always_comb begin
    pickIdx = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (eligible[i]) pickIdx = IDX_STROBE_W'(i);
    end
  end

  assign canLoad   = !validQ || msgReady;
  assign strb.fire = (|eligible) && canLoad;
  assign strb.idx  = pickIdx;

  always_ff @(posedge clk) begin
    if (!rstN)          validQ <= 1'b0;
    else if (strb.fire) validQ <= 1'b1;
    else if (msgReady)  validQ <= 1'b0;
  end

  assign msgValid = validQ;

endmodule

// File: rtl/irq_route_engine.sv
module irq_route_engine
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int IDXW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                entryWrEn,
  input  logic [IDXW-1:0]     entryWrIdx,
  input  logic [63:0]         entryWrData,
  input  logic [IDXW-1:0]     entryRdIdx,
  output logic [63:0]         entryRdData,
  input  logic                eoiValid,
  input  logic [7:0]          eoiVector,
  input  logic [7:0]          extVector,
  output logic                msgValid,
  input  logic                msgReady,
  output logic [31:0]         msgAddr,
  output logic [31:0]         msgData
);

  fire_strobe_t            strb;
  logic [NUM_PINS-1:0]     eligible, pendVec, remoteVec, maskVec, levelVec;
  logic                    fireW;
  logic [IDX_STROBE_W-1:0] fireIdxW;

  irq_route_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
    .clk(clk), .rstN(rstN), .eligible(eligible), .msgReady(msgReady),
    .strb(strb), .msgValid(msgValid)
  );

  irq_route_dp #(.NUM_PINS(NUM_PINS), .IDXW(IDXW)) u_dp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn),
    .wrEn(entryWrEn), .wrIdx(entryWrIdx), .wrData(entryWrData),
    .rdIdx(entryRdIdx), .rdData(entryRdData),
    .eoiValid(eoiValid), .eoiVector(eoiVector), .extVector(extVector),
    .strb(strb), .eligible(eligible), .pendVec(pendVec), .remoteVec(remoteVec),
    .maskVec(maskVec), .levelVec(levelVec), .msgAddr(msgAddr), .msgData(msgData)
  );

  assign fireW    = strb.fire;
  assign fireIdxW = strb.idx;

endmodule

// File: rtl/irq_route_checker.sv
module irq_route_checker #(
  parameter int NUM_PINS = 24
) (
  input logic                clk,
  input logic                rstN,
  input logic                msgValid,
  input logic                msgReady,
  input logic [31:0]         msgAddr,
  input logic [31:0]         msgData,
  input logic                fire,
  input logic [7:0]          fireIdx,
  input logic [NUM_PINS-1:0] pendVec,
  input logic [NUM_PINS-1:0] remoteVec,
  input logic [NUM_PINS-1:0] maskVec,
  input logic [NUM_PINS-1:0] levelVec
);

  logic lowerReady;

  always_comb begin
    lowerReady = 1'b0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if ((8'(i) < fireIdx) && pendVec[i] && !maskVec[i] && (!levelVec[i] || !remoteVec[i]))
        lowerReady = 1'b1;
    end
  end

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgAddr) && $stable(msgData))); // R11

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    fire |-> (!msgValid || msgReady)); // R11

  AST_ADDR_FIXED_BITS: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> (msgAddr[31:20] == 12'hFEE && msgAddr[3] == 1'b0 && msgAddr[1:0] == 2'b00)); // R9

  AST_DATA_ZERO_BITS: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> (msgData[31:16] == 16'h0 && msgData[14:11] == 4'h0)); // R9

  AST_FIRE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    fire |-> pendVec[fireIdx]); // R3

  AST_NO_MASKED_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    fire |-> !maskVec[fireIdx]); // R7

  AST_NO_LEVEL_REFIRE: assert property (@(posedge clk) disable iff (!rstN)
    (fire && levelVec[fireIdx]) |-> !remoteVec[fireIdx]); // R5

  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    fire |-> !lowerReady); // R8

  AST_ENTRY0_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !pendVec[0]); // R2

endmodule

bind irq_route_engine irq_route_checker #(.NUM_PINS(NUM_PINS)) u_irqRouteChk (
  .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgReady(msgReady),
  .msgAddr(msgAddr), .msgData(msgData), .fire(fireW), .fireIdx(fireIdxW),
  .pendVec(pendVec), .remoteVec(remoteVec), .maskVec(maskVec), .levelVec(levelVec)
);

// File: tb/irq_route_engine_bench.sv
`timescale 1ns/1ps
module irq_route_engine_bench;

  localparam int NP = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NP-1:0] pinIn = '0;
  logic          entryWrEn = 1'b0;
  logic [IW-1:0] entryWrIdx = '0;
  logic [63:0]   entryWrData = '0;
  logic [IW-1:0] entryRdIdx = '0;
  logic [63:0]   entryRdData;
  logic          eoiValid = 1'b0;
  logic [7:0]    eoiVector = '0;
  logic [7:0]    extVector = '0;
  logic          msgValid;
  logic          msgReady = 1'b1;
  logic [31:0]   msgAddr, msgData;

  int checks = 0;
  int errors = 0;
  int gotN = 0;
  logic [31:0] gotAddr [256];
  logic [31:0] gotData [256];

  always #4 clk = ~clk;

  irq_route_engine #(.NUM_PINS(NP)) u_irq_route_engine (
    .clk(clk), .rstN(rstN), .pinIn(pinIn),
    .entryWrEn(entryWrEn), .entryWrIdx(entryWrIdx), .entryWrData(entryWrData),
    .entryRdIdx(entryRdIdx), .entryRdData(entryRdData),
    .eoiValid(eoiValid), .eoiVector(eoiVector), .extVector(extVector),
    .msgValid(msgValid), .msgReady(msgReady), .msgAddr(msgAddr), .msgData(msgData)
  );

  always @(posedge clk) begin
    if (rstN && msgValid && msgReady) begin
      gotAddr[gotN % 256] <= msgAddr;
      gotData[gotN % 256] <= msgData;
      gotN <= gotN + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrEntry(input int idx, input logic [63:0] v);
    @(negedge clk);
    entryWrEn = 1'b1; entryWrIdx = IW'(idx); entryWrData = v;
    @(negedge clk);
    entryWrEn = 1'b0;
  endtask

  task automatic rdEntry(input int idx, output logic [63:0] v);
    entryRdIdx = IW'(idx);
    #1;
    v = entryRdData;
  endtask

  task automatic sendEoi(input logic [7:0] vec);
    @(negedge clk);
    eoiValid = 1'b1; eoiVector = vec;
    @(negedge clk);
    eoiValid = 1'b0;
  endtask

  function automatic logic [63:0] mkEntry(input logic [7:0] vec, input logic [2:0] dlv,
      input logic dmode, input logic lvl, input logic msk, input logic [15:0] dest);
    logic [63:0] e;
    e = '0;
    e[7:0] = vec; e[10:8] = dlv; e[11] = dmode; e[15] = lvl; e[16] = msk; e[63:48] = dest;
    return e;
  endfunction

  function automatic logic [31:0] expAddrOf(input logic [15:0] dest, input logic dmode);
    return 32'hFEE0_0000 + {12'h0, dest, 4'h0} + {29'h0, dmode, 2'b00};
  endfunction

  function automatic logic [31:0] expDataOf(input logic [7:0] vec, input logic [2:0] dlv, input logic lvl);
    return {16'h0, lvl, 15'h0} + {21'h0, dlv, 8'h0} + {24'h0, vec};
  endfunction

  logic [63:0] rv;
  logic [31:0] expA, expD, holdA, holdD;
  logic [15:0] dst;
  int base;
  bit stableOk;

  initial begin
    tick(4);
    rstN = 1'b1;
    tick(1);

    // R1 reset state
    chk(msgValid == 1'b0, "R1 msgValid after reset", msgValid, 0);
    for (int i = 0; i < NP; i++) begin
      rdEntry(i, rv);
      chk(rv == 64'h1_0000, "R1 entry reset value", rv, 64'h1_0000);
    end

    // R3 / R9 sweep over inputs 1..7, edge mode
    for (int p = 1; p < NP; p++) begin
      dst = 16'(p * 16'h1111);
      wrEntry(p, mkEntry(8'(8'h20 + p), 3'(p % 4), p[0], 1'b0, 1'b0, dst));
      tick(3);
      base = gotN;
      pinIn[p] = 1'b1;
      tick(12);
      pinIn[p] = 1'b0;
      tick(3);
      chk(gotN - base == 1, "R3 single message per edge", 64'(gotN - base), 1);
      expA = expAddrOf(dst, p[0]);
      expD = expDataOf(8'(8'h20 + p), 3'(p % 4), 1'b0);
      chk(gotAddr[base % 256] == expA, "R9 address fields", gotAddr[base % 256], expA);
      chk(gotData[base % 256] == expD, "R9 data fields", gotData[base % 256], expD);
    end

    // R2 input 0 lands on entry 2; entry 0 unmasked stays silent
    wrEntry(0, mkEntry(8'h40, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0));
    tick(2);
    base = gotN;
    pinIn[0] = 1'b1;
    tick(8);
    pinIn[0] = 1'b0;
    tick(3);
    chk(gotN - base == 1, "R2 input 0 gives one message", 64'(gotN - base), 1);
    chk(gotData[base % 256][7:0] == 8'h22, "R2 vector of entry 2", gotData[base % 256][7:0], 8'h22);

    // R4 masked edge discarded, unmask later emits nothing
    wrEntry(3, mkEntry(8'h33, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0));
    base = gotN;
    pinIn[3] = 1'b1; tick(3); pinIn[3] = 1'b0; tick(3);
    wrEntry(3, mkEntry(8'h33, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0));
    tick(8);
    chk(gotN == base, "R4 masked edge discarded", 64'(gotN - base), 0);

    // R5 level delivery sets remote-pending, held off while set
    wrEntry(4, mkEntry(8'h54, 3'd1, 1'b1, 1'b1, 1'b0, 16'h00AB));
    base = gotN;
    pinIn[4] = 1'b1;
    tick(12);
    chk(gotN - base == 1, "R5 one level message", 64'(gotN - base), 1);
    expD = expDataOf(8'h54, 3'd1, 1'b1);
    chk(gotData[base % 256] == expD, "R5 level data trigger bit", gotData[base % 256], expD);
    rdEntry(4, rv);
    chk(rv[14] == 1'b1, "R5 remote-pending set", rv[14], 1);

    // R6 mismatching EOI does nothing
    base = gotN;
    sendEoi(8'h55);
    tick(6);
    rdEntry(4, rv);
    chk(gotN == base && rv[14], "R6 mismatched EOI ignored", {rv[14], 32'(gotN - base)}, 64'h1_0000_0000);
    // R6 matching EOI with input high redelivers
    sendEoi(8'h54);
    tick(6);
    rdEntry(4, rv);
    chk(gotN - base == 1, "R6 redelivery after EOI", 64'(gotN - base), 1);
    chk(rv[14] == 1'b1, "R6 remote set again", rv[14], 1);
    // R6 matching EOI with input low: cleared, no delivery
    pinIn[4] = 1'b0;
    tick(2);
    base = gotN;
    sendEoi(8'h54);
    tick(6);
    rdEntry(4, rv);
    chk(gotN == base, "R6 no delivery with input low", 64'(gotN - base), 0);
    chk(rv[14] == 1'b0, "R6 remote cleared", rv[14], 0);

    // R12 bit 14 not writable; edge write clears it
    wrEntry(4, mkEntry(8'h54, 3'd1, 1'b1, 1'b1, 1'b0, 16'h00AB) | 64'h4000);
    rdEntry(4, rv);
    chk(rv[14] == 1'b0, "R12 write of bit 14 ignored", rv[14], 0);
    pinIn[4] = 1'b1; tick(6); pinIn[4] = 1'b0; tick(3);
    wrEntry(4, mkEntry(8'h54, 3'd1, 1'b1, 1'b1, 1'b0, 16'h00AB));
    rdEntry(4, rv);
    chk(rv[14] == 1'b1, "R12 remote kept across level write", rv[14], 1);
    base = gotN;
    wrEntry(4, mkEntry(8'h54, 3'd1, 1'b1, 1'b0, 1'b0, 16'h00AB));
    rdEntry(4, rv);
    chk(rv[14] == 1'b0, "R12 edge write clears remote", rv[14], 0);
    tick(5);
    chk(gotN == base, "R12 edge switch emits nothing", 64'(gotN - base), 0);

    // R7 masked level keeps pending, unmask delivers
    wrEntry(5, mkEntry(8'h65, 3'd0, 1'b0, 1'b1, 1'b1, 16'h0005));
    base = gotN;
    pinIn[5] = 1'b1;
    tick(8);
    chk(gotN == base, "R7 masked level silent", 64'(gotN - base), 0);
    wrEntry(5, mkEntry(8'h65, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0005));
    tick(6);
    chk(gotN - base == 1, "R7 unmask delivers", 64'(gotN - base), 1);
    pinIn[5] = 1'b0;
    tick(2);
    sendEoi(8'h65);
    tick(2);

    // R8 / R11 ordering and stall
    wrEntry(1, mkEntry(8'h71, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0));
    wrEntry(3, mkEntry(8'h73, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0));
    wrEntry(6, mkEntry(8'h76, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0));
    @(negedge clk);
    msgReady = 1'b0;
    base = gotN;
    pinIn[1] = 1'b1; pinIn[3] = 1'b1; pinIn[6] = 1'b1;
    tick(4);
    holdA = msgAddr; holdD = msgData;
    stableOk = msgValid;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (!msgValid || msgAddr != holdA || msgData != holdD) stableOk = 1'b0;
    end
    chk(stableOk, "R11 output held under stall", {msgValid, msgData}, {1'b1, holdD});
    chk(gotN == base, "R11 nothing accepted while not ready", 64'(gotN - base), 0);
    chk(holdD[7:0] == 8'h71, "R8 lowest entry first", holdD[7:0], 8'h71);
    msgReady = 1'b1;
    tick(10);
    chk(gotN - base == 3, "R8 three messages", 64'(gotN - base), 3);
    chk(gotData[(base + 1) % 256][7:0] == 8'h73, "R8 second entry", gotData[(base + 1) % 256][7:0], 8'h73);
    chk(gotData[(base + 2) % 256][7:0] == 8'h76, "R8 third entry", gotData[(base + 2) % 256][7:0], 8'h76);
    pinIn = '0;
    tick(3);

    // R10 external vector
    extVector = 8'hA5;
    wrEntry(7, mkEntry(8'h11, 3'b111, 1'b0, 1'b0, 1'b0, 16'h0003));
    base = gotN;
    pinIn[7] = 1'b1; tick(8); pinIn[7] = 1'b0; tick(3);
    expD = expDataOf(8'hA5, 3'b111, 1'b0);
    chk(gotN - base == 1 && gotData[base % 256] == expD, "R10 external vector used", gotData[base % 256], expD);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule